// File: doc/BRIEF.md
# Power-up strap latch with test clock dividers

This block reads four configuration straps while the chip comes out of power-on reset and keeps them in a register for the rest of the session. One strap chooses the bus clock mode and three select the frequency code. The same four pins later carry clock outputs, so the block runs its own reset interval, counted in reference cycles. It samples the straps on the last edge of that interval and then raises the output enables that turn the pins around.

When the latched frequency code holds the production test pattern, the block drives its test clocks from the reference. The reference output is the reference itself, gated cleanly. The CPU group and the fast fixed output run at half the reference rate, and the slow fixed output at a quarter. The bus group runs at a quarter or a third of the reference rate, depending on the latched bus-mode strap. The divide-by-3 path uses both reference edges so that its duty cycle is 50%. Every divider starts from the same phase on the first edge after the test mode turns on. Outside test mode all test clocks stay low.

Top module: `strap_clkgen_top`

## Requirements
- R1: While `por_n` is low, and until the POR_CYCLES-th rising reference edge after its release, all output enables, the test flag and every test clock are low.
- R2: The latched configuration equals the strap inputs present at the POR_CYCLES-th rising edge after reset release. Before that edge it reads all ones, which is the level of an undriven, pulled-up strap.
- R3: After capture, the latched configuration does not change, whatever the straps do, until `por_n` is asserted again.
- R4: From the capture edge onward, all four bits of `oe_shared` are high.
- R5: After capture, `test_active` is high exactly when the latched frequency code has bit 0 = 1, bit 1 = 1 and bit 2 = 0 (`cfg_freq` = 3'b011).
- R6: In test mode, `tclk_ref` follows the reference clock, starting with the high phase that begins at capture edge + 1, and it is low outside test mode.
- R7: In test mode, every `tclk_cpu` bit and `tclk_fast_fixed` run at REF/2, and `tclk_slow_fixed` runs at REF/4 (two cycles high, two low). All of them go high on capture edge + 1.
- R8: In test mode with latched bus mode 1, every `tclk_bus` bit runs at REF/4 in phase with `tclk_slow_fixed`. With bus mode 0 it runs at REF/3: it rises on capture edge + 1 and stays high for 1.5 reference cycles, falling on a falling edge.
- R9: After capture with a frequency code other than the test code, all test clocks stay low.
- R10: Asserting `por_n` low at any time clears the enables and the test flag and returns the configuration to all ones at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| strap_bus_mode | input | 1 | Bus-mode strap level on its shared pin |
| strap_freq | input | 3 | Frequency-select strap levels |
| cfg_bus_mode | output | 1 | Latched bus-mode strap |
| cfg_freq | output | 3 | Latched frequency code |
| test_active | output | 1 | Production test mode decoded from the latched code |
| oe_shared | output | 4 | Output enable per shared pin (bit 0 bus-mode pin, bits 3:1 frequency pins) |
| tclk_ref | output | 1 | Gated reference in test mode |
| tclk_cpu | output | N_CPU_CLK | CPU-group test clocks |
| tclk_bus | output | N_BUS_CLK | Bus-group test clocks |
| tclk_fast_fixed | output | 1 | Fast fixed-rate test clock (REF/2) |
| tclk_slow_fixed | output | 1 | Slow fixed-rate test clock (REF/4) |

## Verification
The bench runs a power-up with the test code and bus mode 1, and another with bus mode 0. The only difference between the two runs is whether the bus group divides by four or by three. Both runs sample the clocks just after rising and falling edges, so the bench can see the half-cycle fall of the odd divider. Each run presents a different strap value before the final reset edge and changes the straps after it, which shows which edge captures them. A near-miss code (3'b010) and an all-ones code show that the decode needs all three bits. A reset asserted in the middle of a test-mode run shows that the enables are cleared without a clock.

// File: rtl/strapgen_pkg.sv
package strapgen_pkg;

  typedef struct packed {
    logic       bus_mode;
    logic [2:0] freq;
  } strap_cfg_t;

  localparam logic [2:0] TEST_FREQ_CODE = 3'b011;

  function automatic logic is_test_code(strap_cfg_t c);
    return c.freq == TEST_FREQ_CODE;
  endfunction

  // high for the first half of an even divider's phase count
  function automatic logic even_div_high(int unsigned phase, int unsigned div);
    return phase < (div / 2);
  endfunction

endpackage

// File: rtl/strap_por_seq.sv
module strap_por_seq
  import strapgen_pkg::*;
#(
  parameter int unsigned POR_CYCLES = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  strap_cfg_t strap_in,
  output strap_cfg_t cfg,
  output logic       done
);
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          capture_evt;

  assign capture_evt = !done && (cnt == CW'(POR_CYCLES - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt  <= '0;
      done <= 1'b0;
      cfg  <= '1;
    end else if (capture_evt) begin
      cfg  <= strap_in;
      done <= 1'b1;
      cnt  <= cnt + 1'b1;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: capture happens only after the full count
  a_r2_capture_at_count: assert property (@(posedge clk) disable iff (!por_n)
    $rose(done) |-> $past(cnt) == CW'(POR_CYCLES - 1));

  // R3: configuration frozen after capture
  a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!por_n)
    done |=> $stable(cfg));

  // R4: enable source never drops without reset
  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!por_n)
    done |=> done);

endmodule

// File: rtl/even_divider.sv
module even_divider
  import strapgen_pkg::*;
#(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic clk_out
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      clk_out <= 1'b0;
    end else if (!run) begin
      phase   <= '0;
      clk_out <= 1'b0;
    end else begin
      phase   <= (phase == PW'(DIV - 1)) ? '0 : phase + 1'b1;
      clk_out <= even_div_high(32'(phase), DIV);
    end
  end

  // R1: idle divider output low one edge after run drops
  a_r1_even_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !clk_out);

  // R7: first running edge starts a high phase
  a_r7_even_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> clk_out);

endmodule

// File: rtl/odd3_divider.sv
module odd3_divider (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic clk_out
);
  logic [1:0] phase;
  logic       rise_q;
  logic       fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      rise_q <= 1'b0;
    end else if (!run) begin
      phase  <= '0;
      rise_q <= 1'b0;
    end else begin
      phase  <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
      rise_q <= (phase == 2'd0);
    end
  end

  // half-cycle stretch of the rising-edge pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= rise_q;
  end

  assign clk_out = rise_q | fall_q;

  // R8: the rising-edge pulse lasts exactly one reference cycle
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rise_q) |=> !rise_q);

  // R1: two idle edges leave the output low
  a_r1_odd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> !clk_out);

endmodule

// File: rtl/ref_gate.sv
module ref_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic clk_out
);
  logic en_q;

  // enable changes only while the clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign clk_out = clk & en_q;

endmodule

// File: rtl/strap_clkgen_top.sv
module strap_clkgen_top
  import strapgen_pkg::*;
#(
  parameter int unsigned POR_CYCLES = 16,
  parameter int unsigned N_CPU_CLK  = 8,
  parameter int unsigned N_BUS_CLK  = 6
) (
  input  logic                 ref_clk,
  input  logic                 por_n,
  input  logic                 strap_bus_mode,
  input  logic [2:0]           strap_freq,
  output logic                 cfg_bus_mode,
  output logic [2:0]           cfg_freq,
  output logic                 test_active,
  output logic [3:0]           oe_shared,
  output logic                 tclk_ref,
  output logic [N_CPU_CLK-1:0] tclk_cpu,
  output logic [N_BUS_CLK-1:0] tclk_bus,
  output logic                 tclk_fast_fixed,
  output logic                 tclk_slow_fixed
);
  localparam int unsigned N_SHARED = $bits(strap_cfg_t);

  strap_cfg_t strap_in;
  strap_cfg_t cfg;
  logic       por_done;
  logic       div2_clk;
  logic       div4_clk;
  logic       div3_clk;
  logic       bus_src;

  assign strap_in.bus_mode = strap_bus_mode;
  assign strap_in.freq     = strap_freq;

  strap_por_seq #(.POR_CYCLES(POR_CYCLES)) u_seq (
    .clk      (ref_clk),
    .por_n    (por_n),
    .strap_in (strap_in),
    .cfg      (cfg),
    .done     (por_done)
  );

  assign cfg_bus_mode = cfg.bus_mode;
  assign cfg_freq     = cfg.freq;
  assign test_active  = por_done && is_test_code(cfg);
  assign oe_shared    = {N_SHARED{por_done}};

  even_divider #(.DIV(2)) u_div2 (
    .clk(ref_clk), .rst_n(por_n), .run(test_active), .clk_out(div2_clk));

  even_divider #(.DIV(4)) u_div4 (
    .clk(ref_clk), .rst_n(por_n), .run(test_active), .clk_out(div4_clk));

  odd3_divider u_div3 (
    .clk(ref_clk), .rst_n(por_n), .run(test_active), .clk_out(div3_clk));

  ref_gate u_gate (
    .clk(ref_clk), .rst_n(por_n), .en(test_active), .clk_out(tclk_ref));

  assign bus_src         = cfg.bus_mode ? div4_clk : div3_clk;
  assign tclk_fast_fixed = div2_clk;
  assign tclk_slow_fixed = div4_clk;

  for (genvar i = 0; i < N_CPU_CLK; i++) begin : g_cpu
    assign tclk_cpu[i] = div2_clk;
  end

  for (genvar i = 0; i < N_BUS_CLK; i++) begin : g_bus
    assign tclk_bus[i] = bus_src;
  end

  // R5: test flag only with the test code latched
  a_r5_flag_needs_code: assert property (@(posedge ref_clk) disable iff (!por_n)
    test_active |-> (cfg_freq == 3'b011));

  // R4: pins are outputs whenever test clocks run
  a_r4_oe_in_test: assert property (@(posedge ref_clk) disable iff (!por_n)
    test_active |-> (oe_shared == '1));

  // R9: no clock activity outside test mode
  a_r9_quiet_non_test: assert property (@(posedge ref_clk) disable iff (!por_n)
    (!test_active && $past(!test_active)) |-> (tclk_cpu == '0 && tclk_bus == '0 && !tclk_slow_fixed));

endmodule

// File: tb/strap_clkgen_top_test.sv
`timescale 1ns/1ps
module strap_clkgen_top_test;
  localparam int POR = 16;
  localparam int NC  = 8;
  localparam int NB  = 6;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          s_bus = 1'b1;
  logic [2:0]    s_freq = 3'b111;
  logic          cfg_bus_mode;
  logic [2:0]    cfg_freq;
  logic          test_active;
  logic [3:0]    oe_shared;
  logic          tclk_ref;
  logic [NC-1:0] tclk_cpu;
  logic [NB-1:0] tclk_bus;
  logic          tclk_fast_fixed;
  logic          tclk_slow_fixed;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  strap_clkgen_top #(.POR_CYCLES(POR), .N_CPU_CLK(NC), .N_BUS_CLK(NB)) uut (
    .ref_clk(clk), .por_n(por_n), .strap_bus_mode(s_bus), .strap_freq(s_freq),
    .cfg_bus_mode(cfg_bus_mode), .cfg_freq(cfg_freq), .test_active(test_active),
    .oe_shared(oe_shared), .tclk_ref(tclk_ref), .tclk_cpu(tclk_cpu),
    .tclk_bus(tclk_bus), .tclk_fast_fixed(tclk_fast_fixed),
    .tclk_slow_fixed(tclk_slow_fixed));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] clocks_now();
    return {27'd0, tclk_ref, (tclk_cpu == '1), (tclk_bus == '1), tclk_fast_fixed, tclk_slow_fixed};
  endfunction

  function automatic logic [31:0] clocks_any();
    return {31'd0, tclk_ref | (|tclk_cpu) | (|tclk_bus) | tclk_fast_fixed | tclk_slow_fixed};
  endfunction

  // expected {ref, cpu, bus, fast, slow} after capture edge + j
  function automatic logic [31:0] exp_clocks(int j, bit pos, bit bm);
    logic r, d2, d4, d3;
    if (j < 1) return 32'd0;
    r  = pos;
    d2 = ((j - 1) % 2) == 0;
    d4 = ((j - 1) % 4) < 2;
    if (pos) d3 = (((j - 1) % 3) == 0) || (j >= 2 && ((j - 2) % 3) == 0);
    else     d3 = ((j - 1) % 3) == 0;
    return {27'd0, r, d2, (bm ? d4 : d3), d2, d4};
  endfunction

  // reset, count out the interval, present s_final just before the capture edge
  task automatic bring_up(input logic [3:0] s_early, input logic [3:0] s_final);
    por_n = 1'b0;
    {s_bus, s_freq} = s_early;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 oe in reset", 32'(oe_shared), 32'h0);
    chk("R10 cfg ones in reset", 32'({cfg_bus_mode, cfg_freq}), 32'hF);
    @(negedge clk) por_n = 1'b1;
    for (int e = 1; e < POR; e++) begin
      @(posedge clk);
      #1;
      if (e == POR - 1) begin
        chk("R1 oe before capture", 32'(oe_shared), 32'h0);
        chk("R1 flag before capture", 32'(test_active), 32'h0);
        chk("R1 clocks before capture", clocks_any(), 32'h0);
        chk("R2 cfg ones before capture", 32'({cfg_bus_mode, cfg_freq}), 32'hF);
      end
    end
    @(negedge clk) {s_bus, s_freq} = s_final;
    @(posedge clk);
    #1;
  endtask

  task automatic run_test_mode(input bit bm);
    logic [3:0] fin;
    fin = {bm, 3'b011};
    bring_up({~bm, 3'b100}, fin);
    chk("R2 cfg at capture", 32'({cfg_bus_mode, cfg_freq}), 32'(fin));
    chk("R4 oe after capture", 32'(oe_shared), 32'hF);
    chk("R5 test flag", 32'(test_active), 32'h1);
    @(negedge clk) {s_bus, s_freq} = ~fin;
    #1;
    chk("R6 R7 R8 clocks edge0 low", clocks_now(), 32'h0);
    for (int j = 1; j <= 12; j++) begin
      @(posedge clk);
      #1;
      chk(bm ? "R6 R7 R8 rise sample mode1" : "R6 R7 R8 rise sample mode0",
          clocks_now(), exp_clocks(j, 1'b1, bm));
      chk("R7 cpu group uniform", 32'(tclk_cpu == {NC{tclk_cpu[0]}}), 32'h1);
      @(negedge clk);
      #1;
      chk(bm ? "R6 R7 R8 fall sample mode1" : "R6 R7 R8 fall sample mode0",
          clocks_now(), exp_clocks(j, 1'b0, bm));
      chk("R8 bus group uniform", 32'(tclk_bus == {NB{tclk_bus[0]}}), 32'h1);
    end
    chk("R3 cfg held after strap change", 32'({cfg_bus_mode, cfg_freq}), 32'(fin));
  endtask

  task automatic run_non_test(input logic [3:0] fin);
    bring_up(~fin, fin);
    chk("R2 cfg non-test", 32'({cfg_bus_mode, cfg_freq}), 32'(fin));
    chk("R4 oe non-test", 32'(oe_shared), 32'hF);
    chk("R5 flag low non-test", 32'(test_active), 32'h0);
    for (int j = 1; j <= 8; j++) begin
      @(posedge clk);
      #1;
      chk("R9 clocks low rise", clocks_any(), 32'h0);
      @(negedge clk);
      #1;
      chk("R9 clocks low fall", clocks_any(), 32'h0);
    end
  endtask

  task automatic run_mid_reset();
    bring_up(4'b0000, 4'b1011);
    repeat (5) @(posedge clk);
    #1;
    chk("R5 flag before reassert", 32'(test_active), 32'h1);
    por_n = 1'b0;
    #0.5;
    chk("R10 oe cleared at once", 32'(oe_shared), 32'h0);
    chk("R10 flag cleared at once", 32'(test_active), 32'h0);
    chk("R10 cfg ones at once", 32'({cfg_bus_mode, cfg_freq}), 32'hF);
    chk("R10 clocks low at once", 32'({tclk_cpu[0], tclk_bus[0], tclk_fast_fixed, tclk_slow_fixed}), 32'h0);
  endtask

  initial begin
    run_test_mode(1'b1);
    run_test_mode(1'b0);
    run_non_test(4'b0010);
    run_non_test(4'b1111);
    run_mid_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule